// File: doc/BRIEF.md
# Packed Byte Logical Right Shift Unit

This execution slice takes one 32-bit instruction word and a 64-bit source operand each cycle. It decodes the word in one of two selectable instruction encodings, a compact one and a standard one. When the word names the packed-byte right shift, the slice splits the low 32 bits of the operand into four 8-bit lanes. It shifts every lane right by the same 3-bit immediate and fills each lane with zeros from the top. The top bit of the upper lane's result is then copied across the upper 32 bits of the 64-bit result.

The result, the destination register index and a valid flag are registered, so they appear one clock after the word is presented. A word that does not match the pattern of the active encoding raises a reserved-instruction flag. A matching word that arrives while the DSP enable is low raises a DSP-disabled flag. In both cases nothing is committed, and the result and destination registers hold their previous values. The source register index is decoded combinationally so that a register file can be read in the same cycle.

Top module: `pbs_top`

## Requirements
- R1: Result bits 31..0 hold four 8-bit lanes (bits 31..24, 23..16, 15..8, 7..0). Each lane is the matching source lane shifted right logically by the immediate, with zeros shifted in at its top. No bit crosses a lane boundary, and source bits 63..32 have no effect on the result.
- R2: A shift amount of 0 returns every source lane unchanged.
- R3: Result bits 63..32 are all copies of result bit 31.
- R4: With encMode = 0, the slice accepts a word whose bits are 31..26 = 011111, 25..24 = 00 and 10..6 = 00001, and 5..0 = 010011. In that word the shift amount is bits 23..21, the source index is bits 20..16 (on srcSel) and the destination index is bits 15..11.
- R5: With encMode = 1, the slice accepts a word whose bits are 31..26 = 000000, 12..6 = 1100001 and 5..0 = 111100. In that word the destination index is bits 25..21, the source index is bits 20..16 (on srcSel) and the shift amount is bits 15..13.
- R6: A word that does not match the active encoding's pattern sets rsvdInstr on the next cycle with resValid low. This includes a word that matches only the other encoding.
- R7: A matching word with dspEnable low sets dspOff on the next cycle, with resValid and rsvdInstr low.
- R8: resData, resDest and resValid update on the rising edge one cycle after the word. resData and resDest keep their previous values in any cycle where no result is committed.
- R9: A synchronous active-high reset clears resValid, rsvdInstr, dspOff, resData and resDest.
- R10: At most one of resValid, rsvdInstr and dspOff is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| encMode | input | 1 | Encoding select: 0 standard, 1 compact |
| dspEnable | input | 1 | High when DSP operations are allowed |
| instrWord | input | 32 | Instruction word for this cycle |
| srcValue | input | 64 | Source register operand |
| srcSel | output | 5 | Decoded source register index (combinational) |
| resData | output | 64 | Registered shift result |
| resDest | output | 5 | Registered destination register index |
| resValid | output | 1 | Result committed this cycle |
| rsvdInstr | output | 1 | Word did not match the active encoding |
| dspOff | output | 1 | Operation recognised while the DSP unit was disabled |

## Verification
The assertions assume that encMode and instrWord stay stable across each sampling edge, because the zero-fill check recovers the shift amount from the previous cycle's word and mode. The bench changes inputs only on falling edges and presents one word for exactly one cycle before checking. The flag checks assume that dspEnable is driven to a known level at every edge, and the bench never leaves it undriven. The bench also fills source bits 63..32 with arbitrary values, so a correct result shows those bits are ignored.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  localparam int SH_W  = 3;
  localparam int REG_W = 5;
  localparam int IW_W  = 32;

  // standard encoding fixed fields
  localparam logic [5:0] STD_MAJOR = 6'b011111;
  localparam logic [1:0] STD_PAD   = 2'b00;
  localparam logic [4:0] STD_SUB   = 5'b00001;
  localparam logic [5:0] STD_FUNC  = 6'b010011;

  // compact encoding fixed fields
  localparam logic [5:0] CMP_MAJOR = 6'b000000;
  localparam logic [6:0] CMP_SUB   = 7'b1100001;
  localparam logic [5:0] CMP_FUNC  = 6'b111100;

  typedef struct packed {
    logic             commit;
    logic             rsvd;
    logic             dspOff;
    logic [SH_W-1:0]  shamt;
    logic [REG_W-1:0] dest;
  } pbsStrobe_t;
endpackage

// File: rtl/pbs_decode.sv
module pbs_decode
  import pbs_pkg::*;
(
  input  logic            encMode,
  input  logic            dspEnable,
  input  logic [IW_W-1:0] instrWord,
  output pbsStrobe_t      strobe,
  output logic [REG_W-1:0] srcSel
);
  logic stdHit;
  logic cmpHit;
  logic hit;

  always_comb begin
    stdHit = (instrWord[31:26] == STD_MAJOR) && (instrWord[25:24] == STD_PAD) &&
             (instrWord[10:6] == STD_SUB) && (instrWord[5:0] == STD_FUNC);
    cmpHit = (instrWord[31:26] == CMP_MAJOR) && (instrWord[12:6] == CMP_SUB) &&
             (instrWord[5:0] == CMP_FUNC);
    hit    = encMode ? cmpHit : stdHit;
  end

  always_comb begin
    strobe.commit = hit && dspEnable;
    strobe.rsvd   = !hit;
    strobe.dspOff = hit && !dspEnable;
    if (encMode) begin
      strobe.shamt = instrWord[15:13];
      strobe.dest  = instrWord[25:21];
    end else begin
      strobe.shamt = instrWord[23:21];
      strobe.dest  = instrWord[15:11];
    end
    srcSel = instrWord[20:16];
  end
endmodule

// File: rtl/pbs_lanes.sv
module pbs_lanes
  import pbs_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int LANES  = 4,
  parameter int OUT_W  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  pbsStrobe_t        strobe,
  input  logic [OUT_W-1:0]  srcValue,
  output logic [OUT_W-1:0]  resData,
  output logic [REG_W-1:0]  resDest,
  output logic              resValid,
  output logic              rsvdInstr,
  output logic              dspOff
);
  localparam int PACK_W = LANE_W * LANES;
  localparam int EXT_W  = OUT_W - PACK_W;

  logic [PACK_W-1:0] shifted;
  logic [OUT_W-1:0]  fullRes;
  logic              unusedHigh;

  assign unusedHigh = ^srcValue[OUT_W-1:PACK_W];

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    assign shifted[ln*LANE_W +: LANE_W] = srcValue[ln*LANE_W +: LANE_W] >> strobe.shamt;
  end

  assign fullRes = {{EXT_W{shifted[PACK_W-1]}}, shifted};

  always_ff @(posedge clk) begin
    if (rst) begin
      resValid  <= 1'b0;
      rsvdInstr <= 1'b0;
      dspOff    <= 1'b0;
      resData   <= '0;
      resDest   <= '0;
    end else begin
      resValid  <= strobe.commit;
      rsvdInstr <= strobe.rsvd;
      dspOff    <= strobe.dspOff;
      if (strobe.commit) begin
        resData <= fullRes;
        resDest <= strobe.dest;
      end
    end
  end
endmodule

// File: rtl/pbs_top.sv
module pbs_top
  import pbs_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int LANES  = 4,
  parameter int OUT_W  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              encMode,
  input  logic              dspEnable,
  input  logic [IW_W-1:0]   instrWord,
  input  logic [OUT_W-1:0]  srcValue,
  output logic [REG_W-1:0]  srcSel,
  output logic [OUT_W-1:0]  resData,
  output logic [REG_W-1:0]  resDest,
  output logic              resValid,
  output logic              rsvdInstr,
  output logic              dspOff
);
  pbsStrobe_t strobe;

  pbs_decode u_dec (
    .encMode   (encMode),
    .dspEnable (dspEnable),
    .instrWord (instrWord),
    .strobe    (strobe),
    .srcSel    (srcSel)
  );

  pbs_lanes #(.LANE_W(LANE_W), .LANES(LANES), .OUT_W(OUT_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .srcValue  (srcValue),
    .resData   (resData),
    .resDest   (resDest),
    .resValid  (resValid),
    .rsvdInstr (rsvdInstr),
    .dspOff    (dspOff)
  );
endmodule

// File: rtl/pbs_checker.sv
module pbs_checker #(
  parameter int LANE_W = 8,
  parameter int LANES  = 4,
  parameter int OUT_W  = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              encMode,
  input logic              dspEnable,
  input logic [31:0]       instrWord,
  input logic [OUT_W-1:0]  resData,
  input logic [4:0]        resDest,
  input logic              resValid,
  input logic              rsvdInstr,
  input logic              dspOff
);
  localparam int PACK_W = LANE_W * LANES;

  logic [2:0] shPrev;
  logic       topClear;

  always_ff @(posedge clk) begin
    shPrev <= encMode ? instrWord[15:13] : instrWord[23:21];
  end

  always_comb begin
    topClear = 1'b1;
    for (int ln = 0; ln < LANES; ln++) begin
      if ((resData[ln*LANE_W +: LANE_W] >> (LANE_W - int'(shPrev))) != '0)
        topClear = 1'b0;
    end
  end

  a_r10_one_status: assert property (@(posedge clk) disable iff (rst)
    $onehot0({resValid, rsvdInstr, dspOff}));

  a_r3_upper_copy: assert property (@(posedge clk) disable iff (rst)
    resValid |-> (resData[OUT_W-1:PACK_W] == {(OUT_W-PACK_W){resData[PACK_W-1]}}));

  a_r8_hold_result: assert property (@(posedge clk) disable iff (rst)
    (!resValid && !$past(rst)) |-> ($stable(resData) && $stable(resDest)));

  a_r7_dsp_gate: assert property (@(posedge clk) disable iff (rst)
    dspOff |-> !$past(dspEnable));

  a_r1_zero_fill: assert property (@(posedge clk) disable iff (rst)
    (resValid && !$past(rst)) |-> topClear);
endmodule

bind pbs_top pbs_checker #(.LANE_W(LANE_W), .LANES(LANES), .OUT_W(OUT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .encMode   (encMode),
  .dspEnable (dspEnable),
  .instrWord (instrWord),
  .resData   (resData),
  .resDest   (resDest),
  .resValid  (resValid),
  .rsvdInstr (rsvdInstr),
  .dspOff    (dspOff)
);

// File: tb/sim_pbs_top.sv
module sim_pbs_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        m;
    logic [2:0]  sh;
    logic [4:0]  dst;
    logic [4:0]  srcr;
    logic [31:0] a;
    logic [31:0] e;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{1'b0, 3'd1, 5'd3,  5'd9,  32'h80808080, 32'h40404040},
    '{1'b1, 3'd0, 5'd4,  5'd10, 32'h80808080, 32'h80808080},
    '{1'b0, 3'd4, 5'd5,  5'd11, 32'hFF00FF00, 32'h0F000F00},
    '{1'b1, 3'd7, 5'd6,  5'd12, 32'hFF00FF00, 32'h01000100},
    '{1'b0, 3'd3, 5'd7,  5'd13, 32'hFFFFFFFF, 32'h1F1F1F1F},
    '{1'b1, 3'd2, 5'd8,  5'd14, 32'h12345678, 32'h040D151E},
    '{1'b0, 3'd1, 5'd31, 5'd15, 32'h00FF00FF, 32'h007F007F},
    '{1'b1, 3'd5, 5'd1,  5'd16, 32'hC3A5015A, 32'h06050002},
    '{1'b0, 3'd0, 5'd2,  5'd17, 32'h9F000000, 32'h9F000000},
    '{1'b1, 3'd6, 5'd30, 5'd31, 32'hFEDCBA98, 32'h03030202}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        encMode = 1'b0;
  logic        dspEnable = 1'b1;
  logic [31:0] instrWord = '0;
  logic [63:0] srcValue = '0;
  logic [4:0]  srcSel;
  logic [63:0] resData;
  logic [4:0]  resDest;
  logic        resValid;
  logic        rsvdInstr;
  logic        dspOff;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pbs_top u0 (
    .clk(clk), .rst(rst), .encMode(encMode), .dspEnable(dspEnable),
    .instrWord(instrWord), .srcValue(srcValue), .srcSel(srcSel),
    .resData(resData), .resDest(resDest), .resValid(resValid),
    .rsvdInstr(rsvdInstr), .dspOff(dspOff)
  );

  function automatic logic [31:0] stdWord(logic [2:0] sh, logic [4:0] s, logic [4:0] d);
    return {6'b011111, 2'b00, sh, s, d, 5'b00001, 6'b010011};
  endfunction

  function automatic logic [31:0] cmpWord(logic [2:0] sh, logic [4:0] s, logic [4:0] d);
    return {6'b000000, d, s, sh, 7'b1100001, 6'b111100};
  endfunction

  function automatic logic [63:0] refShift(logic [31:0] a, logic [2:0] sh);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[i*8 +: 8] = a[i*8 +: 8] >> sh;
    return {{32{r[31]}}, r};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive at falling edge, check one full cycle later (after one rising edge)
  task automatic issue(logic m, logic [31:0] w, logic [63:0] src, logic en);
    @(negedge clk);
    encMode = m; instrWord = w; srcValue = src; dspEnable = en;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] keepData;
    logic [4:0]  keepDest;
    // R9: reset state
    repeat (3) @(negedge clk);
    chk("R9 valid", {63'd0, resValid}, 64'd0);
    chk("R9 rsvd", {63'd0, rsvdInstr}, 64'd0);
    chk("R9 dspOff", {63'd0, dspOff}, 64'd0);
    chk("R9 data", resData, 64'd0);
    chk("R9 dest", {59'd0, resDest}, 64'd0);
    rst = 1'b0;

    // R1 R2 R3 R4 R5: table of vectors
    for (int i = 0; i < 10; i++) begin
      logic [31:0] w;
      w = VEC[i].m ? cmpWord(VEC[i].sh, VEC[i].srcr, VEC[i].dst)
                   : stdWord(VEC[i].sh, VEC[i].srcr, VEC[i].dst);
      @(negedge clk);
      encMode = VEC[i].m; instrWord = w; dspEnable = 1'b1;
      srcValue = {$urandom(), VEC[i].a};
      #1;
      chk(VEC[i].m ? "R5 srcSel" : "R4 srcSel", {59'd0, srcSel}, {59'd0, VEC[i].srcr});
      @(negedge clk);
      chk("R1 R2 R3 R8 data", resData, {{32{VEC[i].e[31]}}, VEC[i].e});
      chk(VEC[i].m ? "R5 dest" : "R4 dest", {59'd0, resDest}, {59'd0, VEC[i].dst});
      chk("R8 valid", {63'd0, resValid}, 64'd1);
    end

    // R1 R3: random data in both encodings, every shift amount
    for (int i = 0; i < 48; i++) begin
      logic        m;
      logic [2:0]  sh;
      logic [4:0]  d;
      logic [63:0] s;
      m = i[0]; sh = 3'(i % 8); d = 5'($urandom()); s = {$urandom(), $urandom()};
      issue(m, m ? cmpWord(sh, 5'd0, d) : stdWord(sh, 5'd0, d), s, 1'b1);
      chk("R1 R3 random", resData, refShift(s[31:0], sh));
      chk("R4 R5 random dest", {59'd0, resDest}, {59'd0, d});
    end

    // R6: compact word while standard mode active
    keepData = resData; keepDest = resDest;
    issue(1'b0, cmpWord(3'd2, 5'd1, 5'd9), 64'hFFFF_FFFF_1234_5678, 1'b1);
    chk("R6 rsvd std", {63'd0, rsvdInstr}, 64'd1);
    chk("R6 valid std", {63'd0, resValid}, 64'd0);
    chk("R8 hold data", resData, keepData);
    chk("R8 hold dest", {59'd0, resDest}, {59'd0, keepDest});

    // R6: standard word while compact mode active
    issue(1'b1, stdWord(3'd2, 5'd1, 5'd9), 64'h0, 1'b1);
    chk("R6 rsvd cmp", {63'd0, rsvdInstr}, 64'd1);
    chk("R6 valid cmp", {63'd0, resValid}, 64'd0);
    chk("R8 hold data2", resData, keepData);

    // R6: standard word with one sub-opcode bit flipped
    issue(1'b0, stdWord(3'd1, 5'd1, 5'd9) ^ 32'h0000_0040, 64'h0, 1'b1);
    chk("R6 rsvd flip", {63'd0, rsvdInstr}, 64'd1);
    // R6: standard word with pad bit set
    issue(1'b0, stdWord(3'd1, 5'd1, 5'd9) | 32'h0100_0000, 64'h0, 1'b1);
    chk("R6 rsvd pad", {63'd0, rsvdInstr}, 64'd1);

    // R7: dsp disabled in both encodings
    issue(1'b0, stdWord(3'd3, 5'd2, 5'd20), 64'hAAAA_AAAA_5555_5555, 1'b0);
    chk("R7 dspOff std", {63'd0, dspOff}, 64'd1);
    chk("R7 valid std", {63'd0, resValid}, 64'd0);
    chk("R7 rsvd std", {63'd0, rsvdInstr}, 64'd0);
    chk("R7 hold data", resData, keepData);
    issue(1'b1, cmpWord(3'd3, 5'd2, 5'd20), 64'h0, 1'b0);
    chk("R7 dspOff cmp", {63'd0, dspOff}, 64'd1);
    chk("R7 hold dest", {59'd0, resDest}, {59'd0, keepDest});
    // R7: dsp disabled with an unrecognised word is reserved
    issue(1'b1, 32'hFFFF_FFFF, 64'h0, 1'b0);
    chk("R7 rsvd wins", {61'd0, rsvdInstr, dspOff, resValid}, 64'd4);

    // R10 and R3: lane D top bit clear, then set
    issue(1'b0, stdWord(3'd0, 5'd0, 5'd5), 64'hFFFF_FFFF_7F00_0001, 1'b1);
    chk("R3 clear", resData, 64'h0000_0000_7F00_0001);
    chk("R10 status", {61'd0, rsvdInstr, dspOff, resValid}, 64'd1);
    issue(1'b1, cmpWord(3'd0, 5'd0, 5'd6), 64'h0000_0000_8000_0000, 1'b1);
    chk("R3 set", resData, 64'hFFFF_FFFF_8000_0000);

    // R9: reset after activity
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    instrWord = 32'h0; encMode = 1'b0;
    chk("R9 data after", resData, 64'd0);
    chk("R9 status after", {61'd0, rsvdInstr, dspOff, resValid}, 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule